// File: doc/BRIEF.md
# Programmable Legacy I/O Address Decoder

This block sits on the host side of an LPC bridge and decides which I/O cycles belong to legacy peripherals behind it. Software programs two decode-select registers, which choose the base of each legacy device, and one enable register, which turns each device range on or off. For every I/O cycle the block compares the 16-bit I/O address against the programmed ranges and raises one hit bit per peripheral, plus a combined claim line that the bridge uses to take the cycle.

The ranges differ in shape: single-byte game ports, spans of 2, 4, 8 and 20 bytes, a parallel port with a second window 400h above its main one for extended-capability transfers, and a movable 512-byte window anywhere in the 64 KB I/O space. One port is read-only: when the parallel port sits at 278h, a write to 279h is not claimed and is flagged for forwarding to the legacy expansion bus.

Top module: `lpc_io_decoder`

## Requirements
- R1: Register index 0 holds decode-select A, index 1 holds decode-select B, index 2 holds the enable register, and index 3 reads as zero; a register is written on a clock edge with `reg_we` high, and `reg_rdata` shows the register at `reg_addr` in the same cycle.
- R2: After reset, decode-select A reads 00080020h, decode-select B reads 0 and the enable register reads 0.
- R3: Only bits 22:0 of select A, bits 15:9 of select B and bits 9:0 of the enable register are stored; other written bits are dropped and read as zero.
- R4: Hit bit k can only be high while enable bit k is set; bit 0 parallel, 1 serial A, 2 serial B, 3 audio, 4 MIDI, 5 sound system, 6 floppy, 7 game A, 8 game B, 9 generic window.
- R5: Game B (select A bits 22:19) and game A (bits 18:15) each decode the single port 200h plus the 4-bit field.
- R6: The floppy field (select A bit 14) decodes 3F0h–3F7h when 0 and 370h–377h when 1.
- R7: The sound-system field (bits 13:12) decodes 8 bytes at 530h, 604h, E80h, F40h for codes 0, 1, 2, 3.
- R8: The MIDI field (bits 11:10) decodes 2 bytes at 300h plus 10h times the code.
- R9: The audio field (bits 9:8) decodes 20 bytes at 220h plus 20h times the code.
- R10: Serial A (bits 4:2) and serial B (bits 7:5) decode 8 bytes at, for codes 0 to 7: 3F8h, 2F8h, 220h, 228h, 238h, 2E8h, 338h, 3E8h.
- R11: The parallel field (bits 1:0) decodes 378h–37Fh and 778h–77Fh for code 0, 278h–27Fh and 678h–67Fh for code 1, 3BCh–3BFh and 7BCh–7BFh for code 2, and nothing for code 3.
- R12: With parallel code 1 and parallel enabled, a write to 279h gives no parallel hit and raises `isa_fwd`; a read of 279h is a parallel hit; `isa_fwd` is low in every other case.
- R13: The generic window hits when address bits 15:9 equal select B bits 15:9.
- R14: `lpc_claim` is high exactly when any hit bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low synchronous reset of the registers |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| io_addr | input | 16 | I/O cycle address |
| io_write | input | 1 | 1 for an I/O write, 0 for a read |
| dev_hit | output | 10 | Per-device hit bits, index as in R4 |
| lpc_claim | output | 1 | Any device hit |
| isa_fwd | output | 1 | Write to the read-only port, forward to the legacy bus |

## Verification
The assertions assume that the I/O address, the write flag and the register port are stable around each rising clock edge, since the decode is combinational and is sampled there; the bench changes every input on the falling edge. They also assume that a register write targets a single index per cycle and that decode results are read only after the write edge, which the bench honours by writing, waiting a full cycle, then presenting addresses. Random addresses are drawn mostly from the 200h–7FFh legacy region so that device ranges are hit often, with some drawn across the whole space and some near the generic window base.

// File: rtl/lpcdec_pkg.sv
package lpcdec_pkg;

   localparam int unsigned DEV_NUM  = 10;
   localparam int unsigned DEV_PAR  = 0;
   localparam int unsigned DEV_SERA = 1;
   localparam int unsigned DEV_SERB = 2;
   localparam int unsigned DEV_AUD  = 3;
   localparam int unsigned DEV_MIDI = 4;
   localparam int unsigned DEV_SND  = 5;
   localparam int unsigned DEV_FDC  = 6;
   localparam int unsigned DEV_GAMA = 7;
   localparam int unsigned DEV_GAMB = 8;
   localparam int unsigned DEV_GEN  = 9;

   // extra window: parallel alias 400h above the main range
   localparam int unsigned WIN_ALIAS = DEV_NUM;
   localparam int unsigned WIN_NUM   = DEV_NUM + 1;

   localparam logic [1:0] IDX_SELA = 2'd0;
   localparam logic [1:0] IDX_SELB = 2'd1;
   localparam logic [1:0] IDX_EN   = 2'd2;

   localparam logic [31:0] SELA_RST  = 32'h0008_0020;
   localparam logic [31:0] SELA_MASK = 32'h007F_FFFF;
   localparam logic [31:0] SELB_MASK = 32'h0000_FE00;
   localparam logic [31:0] EN_MASK   = (32'd1 << DEV_NUM) - 32'd1;

   localparam logic [15:0] RO_PORT = 16'h0279;

endpackage

// File: rtl/lpcdec_regs.sv
module lpcdec_regs
   import lpcdec_pkg::*;
#(
   parameter int REG_W = 32,
   parameter int EN_W  = DEV_NUM
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [1:0]       addr,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata,
   output logic [REG_W-1:0] sela_q,
   output logic [REG_W-1:0] selb_q,
   output logic [EN_W-1:0]  en_q
);

   localparam int NREG = 3;

   logic [REG_W-1:0] q [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      localparam logic [REG_W-1:0] MASK_I =
         (i == 0) ? SELA_MASK : (i == 1) ? SELB_MASK : EN_MASK;
      localparam logic [REG_W-1:0] RST_I =
         (i == 0) ? SELA_RST : '0;
      always_ff @(posedge clk) begin
         if (!rst_n)
            q[i] <= RST_I;
         else if (we && (addr == 2'(i)))
            q[i] <= wdata & MASK_I;
      end
   end

   always_comb begin
      case (addr)
         IDX_SELA: rdata = q[0];
         IDX_SELB: rdata = q[1];
         IDX_EN:   rdata = q[2];
         default:  rdata = '0;
      endcase
   end

   assign sela_q = q[0];
   assign selb_q = q[1];
   assign en_q   = q[2][EN_W-1:0];

endmodule

// File: rtl/lpcdec_window.sv
module lpcdec_window #(
   parameter int ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] span,
   input  logic              en,
   output logic              hit
);

   logic [ADDR_W-1:0] off;

   assign off = addr - base;
   assign hit = en && (addr >= base) && (off < span);

endmodule

// File: rtl/lpc_io_decoder.sv
module lpc_io_decoder
   import lpcdec_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int REG_W     = 32,
   parameter bit ECP_ALIAS = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_we,
   input  logic [1:0]          reg_addr,
   input  logic [REG_W-1:0]    reg_wdata,
   output logic [REG_W-1:0]    reg_rdata,
   input  logic [ADDR_W-1:0]   io_addr,
   input  logic                io_write,
   output logic [DEV_NUM-1:0]  dev_hit,
   output logic                lpc_claim,
   output logic                isa_fwd
);

   localparam int GEN_LSB = 9;
   localparam logic [ADDR_W-1:0] ALIAS_OFS = ADDR_W'(16'h0400);

   if (ADDR_W != 16) begin : g_bad_addr
      $error("lpc_io_decoder: ADDR_W must be 16");
   end
   if (REG_W != 32) begin : g_bad_reg
      $error("lpc_io_decoder: REG_W must be 32");
   end

   logic [REG_W-1:0]   sela_q;
   logic [REG_W-1:0]   selb_q;
   logic [DEV_NUM-1:0] en_q;

   lpcdec_regs #(.REG_W(REG_W), .EN_W(DEV_NUM)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (reg_we),
      .addr   (reg_addr),
      .wdata  (reg_wdata),
      .rdata  (reg_rdata),
      .sela_q (sela_q),
      .selb_q (selb_q),
      .en_q   (en_q)
   );

   // field extraction
   logic [3:0] f_gamb, f_gama;
   logic       f_fdc;
   logic [1:0] f_snd, f_midi, f_aud, f_par;
   logic [2:0] f_serb, f_sera;

   assign f_gamb = sela_q[22:19];
   assign f_gama = sela_q[18:15];
   assign f_fdc  = sela_q[14];
   assign f_snd  = sela_q[13:12];
   assign f_midi = sela_q[11:10];
   assign f_aud  = sela_q[9:8];
   assign f_serb = sela_q[7:5];
   assign f_sera = sela_q[4:2];
   assign f_par  = sela_q[1:0];

   function automatic logic [ADDR_W-1:0] ser_base(input logic [2:0] c);
      case (c)
         3'd0:    ser_base = 16'h03F8;
         3'd1:    ser_base = 16'h02F8;
         3'd2:    ser_base = 16'h0220;
         3'd3:    ser_base = 16'h0228;
         3'd4:    ser_base = 16'h0238;
         3'd5:    ser_base = 16'h02E8;
         3'd6:    ser_base = 16'h0338;
         default: ser_base = 16'h03E8;
      endcase
   endfunction

   // window table
   logic [ADDR_W-1:0] w_base [WIN_NUM];
   logic [ADDR_W-1:0] w_span [WIN_NUM];
   logic [WIN_NUM-1:0] w_en;
   logic [WIN_NUM-1:0] w_hit;
   logic               alias_on;

   if (ECP_ALIAS) begin : g_alias
      assign alias_on = (f_par != 2'b11);
   end else begin : g_noalias
      assign alias_on = 1'b0;
   end

   always_comb begin
      case (f_par)
         2'b00:   begin w_base[DEV_PAR] = 16'h0378; w_span[DEV_PAR] = 16'd8; end
         2'b01:   begin w_base[DEV_PAR] = 16'h0278; w_span[DEV_PAR] = 16'd8; end
         2'b10:   begin w_base[DEV_PAR] = 16'h03BC; w_span[DEV_PAR] = 16'd4; end
         default: begin w_base[DEV_PAR] = 16'h0000; w_span[DEV_PAR] = 16'd0; end
      endcase
      w_base[WIN_ALIAS] = w_base[DEV_PAR] + ALIAS_OFS;
      w_span[WIN_ALIAS] = w_span[DEV_PAR];

      w_base[DEV_SERA] = ser_base(f_sera);
      w_span[DEV_SERA] = 16'd8;
      w_base[DEV_SERB] = ser_base(f_serb);
      w_span[DEV_SERB] = 16'd8;

      w_base[DEV_AUD]  = 16'h0220 + {9'd0, f_aud, 5'd0};
      w_span[DEV_AUD]  = 16'd20;

      w_base[DEV_MIDI] = 16'h0300 + {10'd0, f_midi, 4'd0};
      w_span[DEV_MIDI] = 16'd2;

      case (f_snd)
         2'b00:   w_base[DEV_SND] = 16'h0530;
         2'b01:   w_base[DEV_SND] = 16'h0604;
         2'b10:   w_base[DEV_SND] = 16'h0E80;
         default: w_base[DEV_SND] = 16'h0F40;
      endcase
      w_span[DEV_SND] = 16'd8;

      w_base[DEV_FDC]  = f_fdc ? 16'h0370 : 16'h03F0;
      w_span[DEV_FDC]  = 16'd8;

      w_base[DEV_GAMA] = 16'h0200 + {12'd0, f_gama};
      w_span[DEV_GAMA] = 16'd1;
      w_base[DEV_GAMB] = 16'h0200 + {12'd0, f_gamb};
      w_span[DEV_GAMB] = 16'd1;

      w_base[DEV_GEN]  = {selb_q[ADDR_W-1:GEN_LSB], {GEN_LSB{1'b0}}};
      w_span[DEV_GEN]  = ADDR_W'(1 << GEN_LSB);

      w_en = {alias_on & en_q[DEV_PAR], en_q};
   end

   for (genvar w = 0; w < WIN_NUM; w++) begin : g_win
      lpcdec_window #(.ADDR_W(ADDR_W)) u_win (
         .addr (io_addr),
         .base (w_base[w]),
         .span (w_span[w]),
         .en   (w_en[w]),
         .hit  (w_hit[w])
      );
   end

   // read-only port: writes are not claimed but forwarded
   logic ro_write;
   assign ro_write = en_q[DEV_PAR] && io_write && (f_par == 2'b01) && (io_addr == RO_PORT);

   always_comb begin
      dev_hit          = w_hit[DEV_NUM-1:0];
      dev_hit[DEV_PAR] = (w_hit[DEV_PAR] && !ro_write) || w_hit[WIN_ALIAS];
   end

   assign lpc_claim = |dev_hit;
   assign isa_fwd   = ro_write;

endmodule

// File: rtl/lpcdec_chk.sv
module lpcdec_chk
   import lpcdec_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               reg_we,
   input logic [1:0]         reg_addr,
   input logic [DEV_NUM-1:0] wr_en_bits,
   input logic [ADDR_W-1:0]  io_addr,
   input logic               io_write,
   input logic [DEV_NUM-1:0] dev_hit,
   input logic               lpc_claim,
   input logic               isa_fwd,
   input logic [DEV_NUM-1:0] en_q,
   input logic [6:0]         gen_base
);

   // R1
   en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == IDX_EN) |=> (en_q == $past(wr_en_bits)));

   // R4
   en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(dev_hit & ~en_q) == 0);

   // R12
   ro_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      isa_fwd |-> (io_write && io_addr == RO_PORT && !dev_hit[DEV_PAR] && en_q[DEV_PAR]));

   // R13
   gen_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dev_hit[DEV_GEN] == (en_q[DEV_GEN] && io_addr[ADDR_W-1:ADDR_W-7] == gen_base));

   // R14
   claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lpc_claim == ($countones(dev_hit) != 0));

endmodule

bind lpc_io_decoder lpcdec_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_we     (reg_we),
   .reg_addr   (reg_addr),
   .wr_en_bits (reg_wdata[lpcdec_pkg::DEV_NUM-1:0]),
   .io_addr    (io_addr),
   .io_write   (io_write),
   .dev_hit    (dev_hit),
   .lpc_claim  (lpc_claim),
   .isa_fwd    (isa_fwd),
   .en_q       (en_q),
   .gen_base   (selb_q[15:9])
);

// File: tb/tb_lpc_io_decoder.sv
module tb_lpc_io_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [15:0] io_addr = '0;
   logic        io_write = 1'b0;
   logic [9:0]  dev_hit;
   logic        lpc_claim;
   logic        isa_fwd;

   int n_chk = 0;
   int n_fail = 0;

   logic [31:0] sh_a = 32'h0008_0020;
   logic [31:0] sh_b = 32'h0;
   logic [31:0] sh_en = 32'h0;

   always #4 clk = ~clk;

   lpc_io_decoder dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .io_addr(io_addr),
      .io_write(io_write), .dev_hit(dev_hit), .lpc_claim(lpc_claim),
      .isa_fwd(isa_fwd)
   );

   function automatic string dev_tag(input int i);
      case (i)
         0: dev_tag = "R11";
         1, 2: dev_tag = "R10";
         3: dev_tag = "R9";
         4: dev_tag = "R8";
         5: dev_tag = "R7";
         6: dev_tag = "R6";
         7, 8: dev_tag = "R5";
         default: dev_tag = "R13";
      endcase
   endfunction

   function automatic bit inr(input int a, input int lo, input int n);
      return (a >= lo) && (a < lo + n);
   endfunction

   function automatic int ser_lo(input int c);
      int t [8] = '{'h3F8, 'h2F8, 'h220, 'h228, 'h238, 'h2E8, 'h338, 'h3E8};
      return t[c];
   endfunction

   function automatic bit exp_isa(input int a, input bit wr);
      return sh_en[0] && sh_a[1:0] == 2'b01 && wr && a == 'h279;
   endfunction

   function automatic logic [9:0] exp_hits(input int a, input bit wr);
      logic [9:0] h;
      int plo, pn;
      int snd [4] = '{'h530, 'h604, 'hE80, 'hF40};
      case (int'(sh_a[1:0]))
         0: begin plo = 'h378; pn = 8; end
         1: begin plo = 'h278; pn = 8; end
         2: begin plo = 'h3BC; pn = 4; end
         default: begin plo = 0; pn = 0; end
      endcase
      h[0] = (inr(a, plo, pn) || inr(a, plo + 'h400, pn)) && !exp_isa(a, wr);
      h[1] = inr(a, ser_lo(int'(sh_a[4:2])), 8);
      h[2] = inr(a, ser_lo(int'(sh_a[7:5])), 8);
      h[3] = inr(a, 'h220 + 'h20 * int'(sh_a[9:8]), 20);
      h[4] = inr(a, 'h300 + 'h10 * int'(sh_a[11:10]), 2);
      h[5] = inr(a, snd[int'(sh_a[13:12])], 8);
      h[6] = inr(a, sh_a[14] ? 'h370 : 'h3F0, 8);
      h[7] = (a == 'h200 + int'(sh_a[18:15]));
      h[8] = (a == 'h200 + int'(sh_a[22:19]));
      h[9] = (a / 512) == int'(sh_b[15:9]);
      return h & sh_en[9:0];
   endfunction

   task automatic report;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
      case (a)
         2'd0: sh_a = d & 32'h007F_FFFF;
         2'd1: sh_b = d & 32'h0000_FE00;
         2'd2: sh_en = d & 32'h0000_03FF;
         default: ;
      endcase
   endtask

   task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      reg_addr = a;
      #1;
      n_chk++;
      if (reg_rdata !== exp) begin
         n_fail++;
         $display("FAIL %s reg %0d: got %h exp %h", tag, a, reg_rdata, exp);
      end
   endtask

   task automatic io_chk(input int a, input bit wr, input string tag);
      logic [9:0] eh;
      bit ei;
      @(negedge clk);
      io_addr = 16'(a); io_write = wr;
      #1;
      eh = exp_hits(a, wr);
      ei = exp_isa(a, wr);
      n_chk += 3;
      if (dev_hit !== eh) begin
         n_fail++;
         for (int i = 0; i < 10; i++)
            if (dev_hit[i] !== eh[i]) begin
               $display("FAIL %s/%s addr %h wr %0b: hit %b exp %b",
                        tag, dev_tag(i), a, wr, dev_hit, eh);
               break;
            end
      end
      if (lpc_claim !== (eh != 0)) begin
         n_fail++;
         $display("FAIL R14 addr %h: claim %b exp %b", a, lpc_claim, eh != 0);
      end
      if (isa_fwd !== ei) begin
         n_fail++;
         $display("FAIL R12 addr %h wr %0b: isa %b exp %b", a, wr, isa_fwd, ei);
      end
   endtask

   task automatic bit_chk(input int a, input bit wr, input int idx, input bit v, input string tag);
      @(negedge clk);
      io_addr = 16'(a); io_write = wr;
      #1;
      n_chk++;
      if (dev_hit[idx] !== v) begin
         n_fail++;
         $display("FAIL %s addr %h bit %0d: got %b exp %b", tag, a, idx, dev_hit[idx], v);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R2 reset values, R1 index 3
      rd_chk(2'd0, 32'h0008_0020, "R2");
      rd_chk(2'd1, 32'h0, "R2");
      rd_chk(2'd2, 32'h0, "R2");
      rd_chk(2'd3, 32'h0, "R1");
      // R4: nothing decoded while disabled
      io_chk('h3F8, 1'b0, "R4");
      bit_chk('h201, 1'b0, 8, 1'b0, "R4");

      // R3 reserved bits
      wr_reg(2'd0, 32'hFFFF_FFFF);
      rd_chk(2'd0, 32'h007F_FFFF, "R3");
      wr_reg(2'd1, 32'hFFFF_FFFF);
      rd_chk(2'd1, 32'h0000_FE00, "R3");
      wr_reg(2'd2, 32'hFFFF_FFFF);
      rd_chk(2'd2, 32'h0000_03FF, "R3");
      wr_reg(2'd3, 32'hFFFF_FFFF);
      rd_chk(2'd3, 32'h0, "R1");

      // reset-default map, everything enabled
      wr_reg(2'd0, 32'h0008_0020);
      wr_reg(2'd1, 32'h0);
      bit_chk('h201, 1'b0, 8, 1'b1, "R5");
      bit_chk('h200, 1'b0, 7, 1'b1, "R5");
      bit_chk('h3FF, 1'b0, 1, 1'b1, "R10");
      bit_chk('h2F8, 1'b1, 2, 1'b1, "R10");
      bit_chk('h77F, 1'b0, 0, 1'b1, "R11");
      bit_chk('h3F7, 1'b0, 6, 1'b1, "R6");
      bit_chk('h530, 1'b0, 5, 1'b1, "R7");
      bit_chk('h301, 1'b0, 4, 1'b1, "R8");
      bit_chk('h233, 1'b0, 3, 1'b1, "R9");
      bit_chk('h234, 1'b0, 3, 1'b0, "R9");
      bit_chk('h01FF, 1'b0, 9, 1'b1, "R13");

      // R12 read-only port
      wr_reg(2'd0, 32'h0008_0021);
      io_chk('h279, 1'b1, "R12");
      bit_chk('h279, 1'b1, 0, 1'b0, "R12");
      bit_chk('h279, 1'b0, 0, 1'b1, "R12");
      io_chk('h278, 1'b1, "R12");
      io_chk('h67F, 1'b1, "R11");
      // R11 reserved code, R12 no forward when disabled
      wr_reg(2'd0, 32'h0008_0023);
      bit_chk('h378, 1'b0, 0, 1'b0, "R11");
      wr_reg(2'd0, 32'h0008_0021);
      wr_reg(2'd2, 32'h0000_03FE);
      io_chk('h279, 1'b1, "R12");
      // R13 window at the top of I/O space
      wr_reg(2'd2, 32'h0000_03FF);
      wr_reg(2'd1, 32'h0000_FE00);
      bit_chk('hFFFF, 1'b0, 9, 1'b1, "R13");
      bit_chk('hFDFF, 1'b0, 9, 1'b0, "R13");

      // random phase
      for (int it = 0; it < 600; it++) begin
         int a;
         int pick;
         if (it % 25 == 0) begin
            wr_reg(2'd0, $urandom);
            wr_reg(2'd1, $urandom);
            wr_reg(2'd2, $urandom);
         end
         pick = int'($urandom % 4);
         if (pick < 2)
            a = 'h200 + int'($urandom % 'h600);
         else if (pick == 2)
            a = int'($urandom % 'h10000);
         else
            a = int'(sh_b[15:9]) * 512 + int'($urandom % 1024) - 256;
         a = a & 'hFFFF;
         io_chk(a, 1'($urandom), "rand");
      end

      report();
   end

endmodule